// File: doc/BRIEF.md
# ROM Integrity-Check Sequencer

This block steers the boot-time integrity check of a ROM image. An external address counter walks the ROM. The sequencer sends each data word of the lower region to a hash engine over a valid/ready stream, and it marks the final data word with a last flag. The top region of the ROM holds the expected digest. While that region is read, the sequencer asserts a capture enable so that the digest words can be stored outside the block. Those words are never sent to the hash engine, so the counter may advance over them without waiting for the engine.

The counter and the hash engine can finish in either order. The sequencer has separate waiting states for each order, and a direct path for the case where both finish in the same cycle. Once both have finished, it sends a one-cycle start pulse to an external comparator and waits for the comparator to report done.

Every done flag is checked against the current state. A done flag that arrives in the wrong state, a hash error, a comparator alert or a counter fault sends the sequencer to a fail state. The fail state raises the alert and holds it until reset. Reset is synchronous and active high.

Top module: `romchk_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `strm_valid`, `strm_last`, `cmp_start`, `alert` and `digest_capture` are 0, and the sequencer is in the data phase.
- R2: `strm_valid` and `strm_last` are registers that change only on a clock edge where `hash_ready` is 1. At such an edge, `strm_valid` takes `cnt_rd_req` if the sequencer is in the data phase, and 0 otherwise. `strm_last` takes that same value ANDed with `cnt_last_word`.
- R3: The data phase ends only on a clock edge where `strm_valid`, `strm_last` and `hash_ready` are all 1. A handshake on a word that is not the last one leaves the sequencer in the data phase. In the digest phase that follows, `digest_capture` equals NOT `cnt_done`.
- R4: In the digest phase, each edge acts on the pair {`hash_done`, `cnt_done`}. The pair 01 moves to the counter-first wait. The pair 10 moves to the hash-first wait. The pair 11 moves directly to compare. The pair 00 stays in the digest phase.
- R5: If `hash_err` is 1 on an edge where `hash_done` is 1, the sequencer enters the fail state instead of hash-first or compare, and no start pulse is issued.
- R6: The counter-first wait moves to compare when `hash_done` is 1. The hash-first wait keeps `digest_capture` at NOT `cnt_done` and moves to compare when `cnt_done` is 1.
- R7: `cmp_start` is 1 for exactly one cycle: the first cycle spent in compare.
- R8: Compare moves to pass when `cmp_done` is 1. In pass, `cmp_done` is legal and raises no alert.
- R9: Three events send the sequencer to the fail state: `cnt_done` in the data phase, `cmp_done` outside compare and pass, and `hash_done` outside the digest phase and the counter-first wait.
- R10: A `cmp_alert` or `cnt_fault` of 1 in any state sends the sequencer to the fail state.
- R11: `alert` becomes 1 on the cycle after any event that leads to the fail state. It stays 1 and `cmp_start` stays 0, whatever the inputs, until reset returns the sequencer to the data phase. An illegal state encoding is treated as the fail state.
- R12: `cnt_adv_ok` is 1 when `hash_ready` is 1, and is also 1 whenever the sequencer is in the digest phase or the hash-first wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_rd_req | input | 1 | Counter is requesting a data-word read |
| cnt_last_word | input | 1 | The requested word is the final data word |
| cnt_done | input | 1 | Counter has finished the whole image (level) |
| cnt_fault | input | 1 | Counter reports an unexpected change |
| hash_ready | input | 1 | Hash engine accepts a stream word |
| hash_done | input | 1 | Hash engine has produced the digest |
| hash_err | input | 1 | Hash engine error, qualified by hash_done |
| cmp_done | input | 1 | Comparator has finished |
| cmp_alert | input | 1 | Comparator reports a mismatch or fault |
| strm_valid | output | 1 | Stream word is valid |
| strm_last | output | 1 | Stream word is the final data word |
| cnt_adv_ok | output | 1 | Counter may advance |
| digest_capture | output | 1 | Store the current word as part of the expected digest |
| cmp_start | output | 1 | One-cycle comparator start |
| alert | output | 1 | Sticky integrity alert |

## Verification
The end of the hash and the end of the counter can fall in the same cycle. To provoke this, the bench enters the digest phase and raises `hash_done` and `cnt_done` on the same edge. The result is correct if `cmp_start` pulses on the next cycle with no alert, showing that the direct route to compare was taken and no intermediate wait was used. The same collision is repeated with `hash_err` set, and it must then end with the alert and no start pulse. Each single-sided order is exercised as well, so that the two wait states are told apart by when the start pulse arrives.

// File: rtl/romchk_pkg.sv
package romchk_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    S_DATA       = 3'd0,
    S_TAIL       = 3'd1,
    S_ROM_FIRST  = 3'd2,
    S_HASH_FIRST = 3'd3,
    S_COMPARE    = 3'd4,
    S_PASS       = 3'd5,
    S_FAIL       = 3'd6
  } state_t;
endpackage

// File: rtl/romchk_state_reg.sv
module romchk_state_reg
  import romchk_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  state_t state_nxt,
  output state_t state_cur
);
  state_t state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_DATA;
    else     state_q <= state_nxt;
  end

  // any encoding outside the legal set behaves as the fail state
  always_comb begin
    case (state_q)
      S_DATA, S_TAIL, S_ROM_FIRST, S_HASH_FIRST,
      S_COMPARE, S_PASS, S_FAIL: state_cur = state_q;
      default:                   state_cur = S_FAIL;
    endcase
  end
endmodule

// File: rtl/romchk_next_state.sv
module romchk_next_state
  import romchk_pkg::*;
(
  input  state_t state_cur,
  input  logic   hs_last,
  input  logic   hash_done,
  input  logic   hash_err,
  input  logic   cnt_done,
  input  logic   cnt_fault,
  input  logic   cmp_done,
  input  logic   cmp_alert,
  output state_t state_nxt
);
  logic stray_cmp, stray_cnt, stray_hash, violation;
  state_t order_nxt;

  assign stray_cmp  = cmp_done && !(state_cur inside {S_COMPARE, S_PASS});
  assign stray_cnt  = cnt_done && (state_cur == S_DATA);
  assign stray_hash = hash_done && !(state_cur inside {S_TAIL, S_ROM_FIRST});
  assign violation  = stray_cmp | stray_cnt | stray_hash | cmp_alert | cnt_fault;

  always_comb begin
    order_nxt = state_cur;
    case (state_cur)
      S_DATA: if (hs_last) order_nxt = S_TAIL;
      S_TAIL: begin
        case ({hash_done, cnt_done})
          2'b01:   order_nxt = S_ROM_FIRST;
          2'b10:   order_nxt = hash_err ? S_FAIL : S_HASH_FIRST;
          2'b11:   order_nxt = hash_err ? S_FAIL : S_COMPARE;
          default: order_nxt = S_TAIL;
        endcase
      end
      S_ROM_FIRST:  if (hash_done) order_nxt = hash_err ? S_FAIL : S_COMPARE;
      S_HASH_FIRST: if (cnt_done)  order_nxt = S_COMPARE;
      S_COMPARE:    if (cmp_done)  order_nxt = S_PASS;
      S_PASS:       order_nxt = S_PASS;
      default:      order_nxt = S_FAIL;
    endcase
  end

  assign state_nxt = violation ? S_FAIL : order_nxt;
endmodule

// File: rtl/romchk_stream_reg.sv
module romchk_stream_reg (
  input  logic clk,
  input  logic rst,
  input  logic hash_ready,
  input  logic load_word,
  input  logic word_is_last,
  output logic strm_valid,
  output logic strm_last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      strm_valid <= 1'b0;
      strm_last  <= 1'b0;
    end else if (hash_ready) begin
      strm_valid <= load_word;
      strm_last  <= load_word & word_is_last;
    end
  end
endmodule

// File: rtl/romchk_seq.sv
module romchk_seq
  import romchk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cnt_rd_req,
  input  logic cnt_last_word,
  input  logic cnt_done,
  input  logic cnt_fault,
  input  logic hash_ready,
  input  logic hash_done,
  input  logic hash_err,
  input  logic cmp_done,
  input  logic cmp_alert,
  output logic strm_valid,
  output logic strm_last,
  output logic cnt_adv_ok,
  output logic digest_capture,
  output logic cmp_start,
  output logic alert
);
  state_t state_cur, state_nxt;
  logic   hs_last, in_digest;

  romchk_state_reg u_state (
    .clk       (clk),
    .rst       (rst),
    .state_nxt (state_nxt),
    .state_cur (state_cur)
  );

  assign hs_last = strm_valid & strm_last & hash_ready;

  romchk_next_state u_next (
    .state_cur (state_cur),
    .hs_last   (hs_last),
    .hash_done (hash_done),
    .hash_err  (hash_err),
    .cnt_done  (cnt_done),
    .cnt_fault (cnt_fault),
    .cmp_done  (cmp_done),
    .cmp_alert (cmp_alert),
    .state_nxt (state_nxt)
  );

  romchk_stream_reg u_stream (
    .clk          (clk),
    .rst          (rst),
    .hash_ready   (hash_ready),
    .load_word    ((state_cur == S_DATA) & cnt_rd_req),
    .word_is_last (cnt_last_word),
    .strm_valid   (strm_valid),
    .strm_last    (strm_last)
  );

  // digest words bypass the hash engine
  assign in_digest      = state_cur inside {S_TAIL, S_HASH_FIRST};
  assign cnt_adv_ok     = hash_ready | in_digest;
  assign digest_capture = in_digest & ~cnt_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_start <= 1'b0;
      alert     <= 1'b0;
    end else begin
      cmp_start <= (state_cur != S_COMPARE) && (state_nxt == S_COMPARE);
      alert     <= (state_nxt == S_FAIL);
    end
  end
endmodule

// File: rtl/romchk_seq_chk.sv
module romchk_seq_chk
  import romchk_pkg::*;
(
  input logic   clk,
  input logic   rst,
  input logic   hash_ready,
  input logic   hash_done,
  input logic   hash_err,
  input logic   cnt_done,
  input logic   cnt_fault,
  input logic   cmp_alert,
  input logic   strm_valid,
  input logic   strm_last,
  input logic   cmp_start,
  input logic   alert,
  input state_t state_cur
);
  p_valid_hold_r2: assert property (@(posedge clk) disable iff (rst)
    strm_valid && !hash_ready |=> strm_valid && $stable(strm_last));

  p_err_fail_r5: assert property (@(posedge clk) disable iff (rst)
    hash_done && hash_err |=> alert);

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    cmp_start |=> !cmp_start);

  p_start_state_r7: assert property (@(posedge clk) disable iff (rst)
    cmp_start |-> state_cur == S_COMPARE);

  p_early_cnt_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_done && state_cur == S_DATA |=> alert);

  p_fault_r10: assert property (@(posedge clk) disable iff (rst)
    cmp_alert || cnt_fault |=> alert);

  p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    alert |=> alert && !cmp_start);
endmodule

bind romchk_seq romchk_seq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .hash_ready (hash_ready),
  .hash_done  (hash_done),
  .hash_err   (hash_err),
  .cnt_done   (cnt_done),
  .cnt_fault  (cnt_fault),
  .cmp_alert  (cmp_alert),
  .strm_valid (strm_valid),
  .strm_last  (strm_last),
  .cmp_start  (cmp_start),
  .alert      (alert),
  .state_cur  (state_cur)
);

// File: tb/sim_romchk_seq.sv
`timescale 1ns/1ps
module sim_romchk_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_rd_req = 0, cnt_last_word = 0, cnt_done = 0, cnt_fault = 0;
  logic hash_ready = 0, hash_done = 0, hash_err = 0, cmp_done = 0, cmp_alert = 0;
  logic strm_valid, strm_last, cnt_adv_ok, digest_capture, cmp_start, alert;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  romchk_seq u0 (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    cnt_rd_req = 0; cnt_last_word = 0; cnt_done = 0; cnt_fault = 0;
    hash_ready = 0; hash_done = 0; hash_err = 0; cmp_done = 0; cmp_alert = 0;
  endtask

  task automatic do_reset();
    rst = 1; clear_in(); tick(); tick(); rst = 0;
  endtask

  task automatic to_tail();
    hash_ready = 1; cnt_rd_req = 1; cnt_last_word = 0; tick();
    chk("R2 valid loads", strm_valid, 1); chk("R2 last clear", strm_last, 0);
    cnt_last_word = 1; tick();
    chk("R3 non-last handshake stays in data", digest_capture, 0);
    chk("R2 last loads", strm_last, 1);
    cnt_rd_req = 0; cnt_last_word = 0; tick();
    chk("R3 last handshake enters digest", digest_capture, 1);
    chk("R2 valid drops after data", strm_valid, 0);
  endtask

  task automatic t_reset();
    rst = 1; clear_in(); tick();
    chk("R1 valid in reset", strm_valid, 0);
    chk("R1 alert in reset", alert, 0);
    rst = 0; tick();
    chk("R1 valid", strm_valid, 0); chk("R1 last", strm_last, 0);
    chk("R1 start", cmp_start, 0); chk("R1 alert", alert, 0);
    chk("R1 capture", digest_capture, 0);
    chk("R12 adv without ready in data", cnt_adv_ok, 0);
    hash_ready = 1; #1;
    chk("R12 adv with ready", cnt_adv_ok, 1);
  endtask

  task automatic t_stream_hold();
    do_reset();
    cnt_rd_req = 1; cnt_last_word = 1; tick();
    chk("R2 no load without ready", strm_valid, 0);
    hash_ready = 1; tick();
    chk("R2 load with ready", strm_valid, 1);
    hash_ready = 0; cnt_rd_req = 0; cnt_last_word = 0; tick();
    chk("R2 valid held", strm_valid, 1); chk("R2 last held", strm_last, 1);
    chk("R3 no handshake no advance", digest_capture, 0);
    hash_ready = 1; tick();
    chk("R3 late handshake advances", digest_capture, 1);
    hash_ready = 0; #1;
    chk("R12 adv in digest without ready", cnt_adv_ok, 1);
  endtask

  task automatic t_rom_first();
    do_reset(); to_tail();
    hash_ready = 0; cnt_done = 1; tick();
    chk("R4 01 leaves digest", digest_capture, 0);
    chk("R12 adv low in counter-first", cnt_adv_ok, 0);
    chk("R4 01 no start", cmp_start, 0); chk("R4 01 no alert", alert, 0);
    hash_done = 1; tick(); hash_done = 0;
    chk("R6 counter-first then hash starts", cmp_start, 1);
    chk("R6 no alert", alert, 0);
    tick();
    chk("R7 start is one cycle", cmp_start, 0);
    cmp_done = 1; tick(); tick(); tick();
    chk("R8 pass holds without alert", alert, 0);
    cmp_done = 0;
  endtask

  task automatic t_hash_first();
    do_reset(); to_tail();
    hash_done = 1; tick(); hash_done = 0;
    chk("R4 10 hash-first capture", digest_capture, 1);
    chk("R4 10 no start", cmp_start, 0);
    tick();
    chk("R6 waits for counter", cmp_start, 0); chk("R6 no alert", alert, 0);
    cnt_done = 1; #1;
    chk("R6 capture off when counter done", digest_capture, 0);
    tick();
    chk("R6 counter done starts compare", cmp_start, 1);
  endtask

  task automatic t_both();
    do_reset(); to_tail();
    hash_done = 1; cnt_done = 1; tick(); hash_done = 0;
    chk("R4 11 direct start", cmp_start, 1);
    chk("R4 11 no alert", alert, 0);
  endtask

  task automatic t_idle_tail();
    do_reset(); to_tail();
    hash_ready = 0; tick(); tick(); tick();
    chk("R4 00 stays in digest", digest_capture, 1);
    chk("R4 00 no alert", alert, 0);
  endtask

  task automatic t_hash_err();
    do_reset(); to_tail();
    hash_done = 1; hash_err = 1; tick();
    chk("R5 error in digest alerts", alert, 1); chk("R5 no start", cmp_start, 0);
    do_reset(); to_tail();
    cnt_done = 1; tick();
    hash_done = 1; hash_err = 1; tick();
    chk("R5 error in counter-first alerts", alert, 1); chk("R5 no start cf", cmp_start, 0);
    do_reset(); to_tail();
    hash_done = 1; hash_err = 1; cnt_done = 1; tick();
    chk("R5 error on 11 alerts", alert, 1); chk("R5 no start 11", cmp_start, 0);
  endtask

  task automatic t_unexpected();
    do_reset(); cnt_done = 1; tick();
    chk("R9 counter done in data", alert, 1);
    do_reset(); to_tail(); cmp_done = 1; tick();
    chk("R9 compare done in digest", alert, 1);
    do_reset(); to_tail(); hash_done = 1; tick(); tick();
    chk("R9 second hash done in hash-first", alert, 1);
    do_reset(); to_tail(); hash_done = 1; cnt_done = 1; tick();
    hash_done = 0; tick(); hash_done = 1; tick();
    chk("R9 hash done in compare", alert, 1);
  endtask

  task automatic t_faults();
    do_reset(); cnt_fault = 1; tick();
    chk("R10 counter fault", alert, 1);
    do_reset(); to_tail(); hash_done = 1; cnt_done = 1; tick(); hash_done = 0;
    cmp_done = 1; tick(); cmp_done = 0; tick();
    chk("R10 pass before comparator alert", alert, 0);
    cmp_alert = 1; tick();
    chk("R10 comparator alert in pass", alert, 1);
  endtask

  task automatic t_sticky();
    do_reset(); cnt_done = 1; tick(); cnt_done = 0;
    chk("R11 enters fail", alert, 1);
    hash_ready = 1; hash_done = 1; tick(); hash_done = 0; cnt_done = 1; tick();
    cmp_done = 1; tick(); tick();
    chk("R11 alert held", alert, 1); chk("R11 no start in fail", cmp_start, 0);
    do_reset();
    chk("R11 reset clears alert", alert, 0);
    to_tail();
    chk("R11 recovered to digest", alert, 0);
  endtask

  initial begin
    t_reset();
    t_stream_hold();
    t_rom_first();
    t_hash_first();
    t_both();
    t_idle_tail();
    t_hash_err();
    t_unexpected();
    t_faults();
    t_sticky();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule